// File: doc/BRIEF.md
# Write-Enable and Block-Protection Unit

This unit holds the configuration byte and the write-enable latch of a serial byte-addressed memory, and decides from them whether a pending write may proceed. A protocol engine in front of it decodes the serial opcodes and hands over one-cycle pulses: latch set, latch reset, configuration write (with its data byte), array write, and the end of a chip-select frame. The unit answers with the byte the engine shifts out on a status read, a permit for the array write at the address the engine presents, and a permit for a configuration write.

Writes are held off until software has set the latch. The latch clears itself when a frame that carried any write-class command ends. Two protect bits mark no block, the top quarter, the top half or the whole array as read-only. A lock bit lets the active-low write-protect pin freeze the configuration byte. The pin never affects the array. The protect and lock bits would be nonvolatile in silicon; here they are plain registers with a reset default.

The array permit follows the presented address in the same cycle, so the engine can test each byte's address just before it commits that byte.

Top module: `wrprot_unit`

## Requirements
- R1: After reset the status byte reads 8'h40: lock bit (bit 7) 0, protect bits (bits 3:2) 00, latch (bit 1) 0.
- R2: Bit 6 of the status byte always reads 1 and bits 5, 4 and 0 always read 0, whatever data a configuration write carries.
- R3: A latch-set pulse makes bit 1 read 1 from the next cycle on.
- R4: Only a latch-set pulse raises bit 1. Bit 1 of the data in a configuration write is ignored.
- R5: Bit 1 falls on the first frame-end pulse after a latch-reset, configuration-write or array-write pulse. A frame-end pulse with none of these in its frame leaves bit 1 unchanged. Before the frame end, those commands leave bit 1 unchanged.
- R6: Protect bits 00 protect no address. 01 protects the top quarter, i.e. address bits [17:16] = 11 (30000h–3FFFFh). 10 protects the top half, i.e. address bit 17 = 1 (20000h–3FFFFh). 11 protects every address.
- R7: While bit 1 is 0, the array permit and the configuration permit are both 0.
- R8: While bit 1 is 1, the configuration permit is 0 exactly when the lock bit is 1 and the protect pin is low.
- R9: While bit 1 is 1, the array permit is 1 for every unprotected address, whatever the lock bit and the protect pin.
- R10: An allowed configuration write loads data bits 7, 3 and 2 into the lock and protect bits, visible the next cycle.
- R11: A blocked configuration write leaves the lock and protect bits unchanged but still clears bit 1 at the frame end.
- R12: The array permit is combinational in the address and changes in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren_i | input | 1 | Latch-set command pulse |
| cmd_wrdi_i | input | 1 | Latch-reset command pulse |
| cmd_wrsr_i | input | 1 | Configuration-write pulse, qualified with wrsr_data_i |
| wrsr_data_i | input | 8 | Data byte of the configuration write |
| cmd_write_i | input | 1 | Array-write command pulse |
| cs_rise_i | input | 1 | End-of-frame pulse (chip select released) |
| wp_n_i | input | 1 | Active-low hardware write-protect pin |
| wr_addr_i | input | 18 | Address of the pending array byte |
| status_o | output | 8 | Status byte for a status read |
| array_wr_ok_o | output | 1 | Array write permitted at wr_addr_i |
| status_wr_ok_o | output | 1 | Configuration write permitted |

## Verification
On every cycle the assertions check the fixed status bits, the only allowed sources of a rise or fall of the latch, the gating of both permits by the latch and the lock pin, and the block decode against the address. The bench scenarios show the ordering effects. The latch survives the command and clears only at the frame end. A blocked configuration write still consumes the latch. A frame end with no write-class command leaves the latch alone. The array permit responds to an address change within the same cycle.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;

  // Status byte field positions (decoded by the status-read shifter)
  localparam int unsigned ST_LOCK_BIT = 7;
  localparam int unsigned ST_ONE_BIT  = 6;
  localparam int unsigned ST_BPHI_BIT = 3;
  localparam int unsigned ST_BPLO_BIT = 2;
  localparam int unsigned ST_WEL_BIT  = 1;

  typedef enum logic [1:0] {
    ZONE_NONE = 2'b00,
    ZONE_QTR  = 2'b01,
    ZONE_HALF = 2'b10,
    ZONE_ALL  = 2'b11
  } zone_e;

endpackage

// File: rtl/wrprot_wel.sv
module wrprot_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic arm_i,
  input  logic frame_end_i,
  output logic wel_o
);
  logic armed;
  logic drop;

  // Clear happens at frame end when a write-class command was seen in the frame
  assign drop = frame_end_i && (armed || arm_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      wel_o <= 1'b0;
    end else begin
      if (frame_end_i)
        armed <= 1'b0;
      else if (arm_i)
        armed <= 1'b1;

      if (drop)
        wel_o <= 1'b0;
      else if (set_i)
        wel_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wrprot_cfg.sv
module wrprot_cfg
  import wrprot_pkg::*;
#(
  parameter logic       LOCK_RST = 1'b0,
  parameter logic [1:0] BP_RST   = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       lock_o,
  output logic [1:0] bp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o <= LOCK_RST;
      bp_o   <= BP_RST;
    end else if (load_i) begin
      lock_o <= data_i[ST_LOCK_BIT];
      bp_o   <= data_i[ST_BPHI_BIT:ST_BPLO_BIT];
    end
  end
endmodule

// File: rtl/wrprot_zone.sv
module wrprot_zone
  import wrprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bp_i,
  output logic              prot_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic in_half;
  logic in_qtr;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_half = addr_i[TOP];
      assign in_qtr  = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign in_half = addr_i[TOP];
      assign in_qtr  = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (zone_e'(bp_i))
      ZONE_NONE: prot_o = 1'b0;
      ZONE_QTR:  prot_o = in_qtr;
      ZONE_HALF: prot_o = in_half;
      ZONE_ALL:  prot_o = 1'b1;
      default:   prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wrprot_unit.sv
module wrprot_unit
  import wrprot_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter logic        LOCK_RST = 1'b0,
  parameter logic [1:0]  BP_RST   = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              cmd_write_i,
  input  logic              cs_rise_i,
  input  logic              wp_n_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [7:0]        status_o,
  output logic              array_wr_ok_o,
  output logic              status_wr_ok_o
);
  logic       wel;
  logic       lock;
  logic [1:0] bp;
  logic       prot;
  logic       write_class;
  logic       cfg_load;

  assign write_class = cmd_wrdi_i | cmd_wrsr_i | cmd_write_i;

  wrprot_wel u_wel (
    .clk        (clk),
    .rst        (rst),
    .set_i      (cmd_wren_i),
    .arm_i      (write_class),
    .frame_end_i(cs_rise_i),
    .wel_o      (wel)
  );

  // Configuration permit: latch set and not frozen by the pin
  assign status_wr_ok_o = wel & ~(lock & ~wp_n_i);
  assign cfg_load       = cmd_wrsr_i & status_wr_ok_o;

  wrprot_cfg #(
    .LOCK_RST(LOCK_RST),
    .BP_RST  (BP_RST)
  ) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .load_i(cfg_load),
    .data_i(wrsr_data_i),
    .lock_o(lock),
    .bp_o  (bp)
  );

  wrprot_zone #(
    .ADDR_W(ADDR_W)
  ) u_zone (
    .addr_i(wr_addr_i),
    .bp_i  (bp),
    .prot_o(prot)
  );

  assign array_wr_ok_o = wel & ~prot;

  always_comb begin
    status_o              = 8'h00;
    status_o[ST_ONE_BIT]  = 1'b1;
    status_o[ST_LOCK_BIT] = lock;
    status_o[ST_BPHI_BIT] = bp[1];
    status_o[ST_BPLO_BIT] = bp[0];
    status_o[ST_WEL_BIT]  = wel;
  end
endmodule

// File: rtl/wrprot_unit_chk.sv
module wrprot_unit_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_wren_i,
  input logic              cmd_wrsr_i,
  input logic [7:0]        wrsr_data_i,
  input logic              cs_rise_i,
  input logic              wp_n_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        status_o,
  input logic              array_wr_ok_o,
  input logic              status_wr_ok_o
);
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    status_o[6] && !status_o[5] && !status_o[4] && !status_o[0]); // R2

  AST_WEL_SET: assert property (@(posedge clk) disable iff (rst)
    cmd_wren_i && !cs_rise_i |=> status_o[1]); // R3

  AST_WEL_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[1]) |-> $past(cmd_wren_i)); // R4

  AST_WEL_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[1]) |-> $past(cs_rise_i)); // R5

  AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    status_o[3:2] == 2'b11 |-> !array_wr_ok_o); // R6

  AST_QTR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    status_o[3:2] == 2'b01 && wr_addr_i[ADDR_W-1 -: 2] == 2'b11 |-> !array_wr_ok_o); // R6

  AST_HALF_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    status_o[3:2] == 2'b10 && wr_addr_i[ADDR_W-1] |-> !array_wr_ok_o); // R6

  AST_NO_WEL_NO_PERMIT: assert property (@(posedge clk) disable iff (rst)
    !status_o[1] |-> !array_wr_ok_o && !status_wr_ok_o); // R7

  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (rst)
    status_o[1] |-> status_wr_ok_o == !(status_o[7] && !wp_n_i)); // R8

  AST_OPEN_ARRAY: assert property (@(posedge clk) disable iff (rst)
    status_o[1] && status_o[3:2] == 2'b00 |-> array_wr_ok_o); // R9

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    cmd_wrsr_i && status_wr_ok_o |=>
      status_o[7] == $past(wrsr_data_i[7]) && status_o[3:2] == $past(wrsr_data_i[3:2])); // R10

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_wrsr_i && !status_wr_ok_o |=>
      status_o[7] == $past(status_o[7]) && status_o[3:2] == $past(status_o[3:2])); // R11
endmodule

bind wrprot_unit wrprot_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_wren_i    (cmd_wren_i),
  .cmd_wrsr_i    (cmd_wrsr_i),
  .wrsr_data_i   (wrsr_data_i),
  .cs_rise_i     (cs_rise_i),
  .wp_n_i        (wp_n_i),
  .wr_addr_i     (wr_addr_i),
  .status_o      (status_o),
  .array_wr_ok_o (array_wr_ok_o),
  .status_wr_ok_o(status_wr_ok_o)
);

// File: tb/sim_wrprot_unit.sv
`timescale 1ns/1ps
module sim_wrprot_unit;
  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wren = 0, wrdi = 0, wrsr = 0, wr = 0, csr = 0;
  logic [7:0]    sd = 8'h00;
  logic          wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    st;
  logic          aok, sok;

  always #2 clk = ~clk;

  wrprot_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst),
    .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr),
    .wrsr_data_i(sd), .cmd_write_i(wr), .cs_rise_i(csr),
    .wp_n_i(wp_n), .wr_addr_i(addr),
    .status_o(st), .array_wr_ok_o(aok), .status_wr_ok_o(sok)
  );

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic       a;
    logic       s;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  function automatic void compare(string tag, logic [7:0] es, logic ea, logic esk);
    n_chk++;
    if (st !== es || aok !== ea || sok !== esk) begin
      n_fail++;
      $display("FAIL %s: got st=%h a=%b s=%b, expected st=%h a=%b s=%b",
               tag, st, aok, sok, es, ea, esk);
    end
  endfunction

  // Monitor: compares after the edge that follows each driven step
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compare(e.tag, e.st, e.a, e.s);
      end
    end
  end

  // Driver: one cycle of command pulses, then the expected outputs after the edge
  task automatic op(input bit en, input bit di, input bit sr, input bit w,
                    input bit c, input logic [7:0] d,
                    input string tag, input logic [7:0] es, input logic ea, input logic esk);
    exp_t e;
    @(negedge clk);
    wren = en; wrdi = di; wrsr = sr; wr = w; csr = c; sd = d;
    e.tag = tag; e.st = es; e.a = ea; e.s = esk;
    exp_q.push_back(e);
  endtask

  // Same-cycle check of the combinational array permit
  task automatic addr_now(input logic [AW-1:0] a, input logic ea, input string tag);
    @(negedge clk);
    wren = 0; wrdi = 0; wrsr = 0; wr = 0; csr = 0;
    addr = a;
    #0.5;
    n_chk++;
    if (aok !== ea) begin
      n_fail++;
      $display("FAIL %s: addr=%h got a=%b expected a=%b", tag, a, aok, ea);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    op(0,0,0,0,0,8'h00, "R1 reset byte / R7 no permit", 8'h40, 0, 0);
    op(1,0,0,0,0,8'h00, "R3 latch set", 8'h42, 1, 1);
    op(0,0,0,0,1,8'h00, "R5 frame end without write-class keeps latch", 8'h42, 1, 1);
    op(0,0,1,0,0,8'h8C, "R10 lock+protect-all loaded, R5 latch held", 8'hCE, 0, 1);
    op(0,0,0,0,1,8'h00, "R5 frame end clears latch after cfg write", 8'hCC, 0, 0);
    op(1,0,0,0,0,8'h00, "R6 all protected with latch set", 8'hCE, 0, 1);
    @(negedge clk); wp_n = 1'b0;
    op(0,0,0,0,0,8'h00, "R8 pin low with lock freezes cfg", 8'hCE, 0, 0);
    op(0,0,1,0,0,8'h00, "R11 blocked cfg write keeps fields", 8'hCE, 0, 0);
    op(0,0,0,0,1,8'h00, "R11 blocked cfg write still clears latch", 8'hCC, 0, 0);
    @(negedge clk); wp_n = 1'b1;
    op(1,0,0,0,0,8'h00, "R8 pin high allows cfg", 8'hCE, 0, 1);
    op(0,0,1,0,0,8'h37, "R2 R4 fixed bits and latch bit ignored", 8'h46, 1, 1);
    op(0,0,0,0,1,8'h00, "R4 data bit1 did not keep latch", 8'h44, 0, 0);
    op(1,0,0,0,0,8'h00, "R3 latch set again", 8'h46, 1, 1);
    addr_now(18'h2FFFF, 1'b1, "R6 R12 quarter: below top quarter");
    addr_now(18'h30000, 1'b0, "R6 R12 quarter: top quarter start");
    addr_now(18'h3FFFF, 1'b0, "R6 R12 quarter: last address");
    op(0,0,0,1,0,8'h00, "R5 array write holds latch until frame end", 8'h46, 0, 1);
    op(0,0,0,0,1,8'h00, "R5 frame end clears latch after array write", 8'h44, 0, 0);
    op(1,0,0,0,0,8'h00, "R3 latch set", 8'h46, 0, 1);
    op(0,0,1,0,0,8'h08, "R10 protect half loaded", 8'h4A, 0, 1);
    addr_now(18'h1FFFF, 1'b1, "R6 R12 half: below half");
    addr_now(18'h20000, 1'b0, "R6 R12 half: half start");
    op(0,0,0,0,1,8'h00, "R5 clear after cfg write", 8'h48, 0, 0);
    op(1,0,0,0,0,8'h00, "R3 latch set", 8'h4A, 0, 1);
    op(0,1,0,0,0,8'h00, "R5 latch reset waits for frame end", 8'h4A, 0, 1);
    op(0,0,0,0,1,8'h00, "R5 latch reset at frame end", 8'h48, 0, 0);
    op(1,0,0,0,0,8'h00, "R3 latch set", 8'h4A, 0, 1);
    op(0,0,1,0,0,8'h80, "R10 lock only", 8'hC2, 1, 1);
    op(0,0,0,0,1,8'h00, "R5 clear", 8'hC0, 0, 0);
    op(1,0,0,0,0,8'h00, "R3 latch set", 8'hC2, 1, 1);
    @(negedge clk); wp_n = 1'b0; addr = 18'h10000;
    op(0,0,0,0,0,8'h00, "R9 array open despite lock and pin", 8'hC2, 1, 0);
    @(negedge clk); wp_n = 1'b1; addr = 18'h3FFFF;
    op(0,0,1,0,0,8'h00, "R6 R9 no protection at top address", 8'h42, 1, 1);
    op(0,0,0,0,0,8'h00, "R7 idle before frame end", 8'h42, 1, 1);
    op(0,0,0,0,1,8'h00, "R7 permits drop with latch", 8'h40, 0, 0);
    op(0,0,0,0,0,8'h00, "R1 idle", 8'h40, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule